// File: doc/BRIEF.md
# Bfloat16 multiply, single-precision accumulate cell

This cell multiplies two bfloat16 operands and adds the product into a single-precision accumulator, so that a dot product can be built up over successive cycles. The two formats share an 8-bit exponent with the same bias. The exact 16-bit product of the two 8-bit significands therefore fits inside the 24-bit single-precision significand. It is widened to a single-precision value with no rounding, and the only rounding step is the accumulate add, which rounds to nearest, ties to even.

A caller raises `valid_i` with an operand pair on every cycle that contributes a term. It raises `clear_i` together with the first pair of a new dot product, and that pair then replaces the old sum instead of adding to it. A clear without valid simply zeroes the sum. The pipeline takes a new pair every cycle. Each pair appears in `acc_o` two clock edges after it is sampled.

Subnormal operands and subnormal results are flushed to signed zero. A NaN is always the canonical quiet NaN 0x7FC00000. No exception flags are produced.

Top module: `bf16_mac_acc`

## Requirements
- R1: After reset is released, acc_o is 0x00000000 (+0.0).
- R2: A pair (a, b) sampled with valid_i high shows in acc_o after the second rising edge. acc_o then holds the round-to-nearest-even single-precision sum of the previous accumulator and the exact product a*b. Example: 1*7 + 2*11 + 3*15 gives 74.0 (0x42940000).
- R3: A new operand pair is accepted on every cycle. Back-to-back pairs each take effect in turn, one cycle apart.
- R4: With valid_i and clear_i both high, the sum of +0.0 and the product replaces the accumulator.
- R5: With clear_i high and valid_i low, acc_o becomes +0.0 two edges later.
- R6: With valid_i and clear_i both low, acc_o keeps its value whatever the operand inputs carry.
- R7: An add whose discarded part is exactly half an ulp rounds to the even significand: 1.0 + 2^-24 gives 0x3F800000, and (1 + 2^-23) + 2^-24 gives 0x3F800002.
- R8: A NaN operand (exponent 0xFF, fraction nonzero), infinity times zero, or a sum of opposite infinities makes acc_o 0x7FC00000.
- R9: An infinite operand times a finite nonzero operand gives an infinity with the XOR of the operand signs. An infinite accumulator absorbs any finite addend.
- R10: A subnormal operand (exponent 0) counts as signed zero. A product or sum below 2^-126 in magnitude is flushed to zero with its sign. A product above the largest finite value becomes infinity.
- R11: An exact cancellation (x + -x) gives +0.0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair present this cycle |
| clear_i | input | 1 | Start a new sum from +0.0 |
| a_i | input | 16 | First bfloat16 operand |
| b_i | input | 16 | Second bfloat16 operand |
| acc_o | output | 32 | Single-precision accumulator |

## Verification
On every cycle the assertions check four things, each against the inputs sampled two edges earlier. The accumulator holds when nothing was issued. A lone clear yields +0.0. A NaN operand forces the canonical NaN. A cleared infinity-times-finite product yields the correctly signed infinity. The rounding itself can only be shown by the bench's scenarios: the ties to even, the flush of small products and sums, overflow, cancellation, and agreement with the reference over a random stream of back-to-back pairs. The bench computes its expected values independently with double-precision arithmetic and its own rounding to single precision.

// File: rtl/bf16_mac_pkg.sv
package bf16_mac_pkg;
  localparam int BF_FW  = 7;
  localparam int FP_EW  = 8;
  localparam int FP_FW  = 23;
  localparam int FP_W   = 1 + FP_EW + FP_FW;
  localparam int BIAS   = 127;
  localparam int GRS_W  = 3;
  localparam int SIG_W  = FP_FW + 1;
  localparam int ALN_W  = SIG_W + GRS_W;
  localparam int LZ_W   = $clog2(ALN_W + 1);
  localparam logic [FP_W-1:0] QNAN = 32'h7FC0_0000;
endpackage

// File: rtl/bf16_mul_widen.sv
module bf16_mul_widen
  import bf16_mac_pkg::*;
(
  input  logic [15:0]     a_i,
  input  logic [15:0]     b_i,
  output logic [FP_W-1:0] prod_o
);
  localparam int PW = 2 * (BF_FW + 1);

  logic [7:0]        ea, eb;
  logic              sp;
  logic              a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;
  logic [PW-1:0]     sig_p;
  logic signed [9:0] exp_p;
  logic [FP_FW-1:0]  frac_p;

  assign ea     = a_i[14:7];
  assign eb     = b_i[14:7];
  assign sp     = a_i[15] ^ b_i[15];
  assign a_zero = (ea == '0);
  assign b_zero = (eb == '0);
  assign a_inf  = (ea == '1) && (a_i[6:0] == '0);
  assign b_inf  = (eb == '1) && (b_i[6:0] == '0);
  assign a_nan  = (ea == '1) && (a_i[6:0] != '0);
  assign b_nan  = (eb == '1) && (b_i[6:0] != '0);

  // exact significand product, hidden bits included
  assign sig_p = {1'b1, a_i[6:0]} * {1'b1, b_i[6:0]};
  assign exp_p = $signed({2'b00, ea}) + $signed({2'b00, eb}) - 10'sd127
               + $signed({9'd0, sig_p[PW-1]});
  assign frac_p = sig_p[PW-1] ? {sig_p[PW-2:0], {(FP_FW-PW+1){1'b0}}}
                              : {sig_p[PW-3:0], {(FP_FW-PW+2){1'b0}}};

  always_comb begin
    if (a_nan || b_nan || (a_inf && b_zero) || (b_inf && a_zero))
      prod_o = QNAN;
    else if (a_inf || b_inf)
      prod_o = {sp, {FP_EW{1'b1}}, {FP_FW{1'b0}}};
    else if (a_zero || b_zero)
      prod_o = {sp, {(FP_W-1){1'b0}}};
    else if (exp_p >= 10'sd255)
      prod_o = {sp, {FP_EW{1'b1}}, {FP_FW{1'b0}}};
    else if (exp_p <= 10'sd0)
      prod_o = {sp, {(FP_W-1){1'b0}}};
    else
      prod_o = {sp, exp_p[7:0], frac_p};
  end
endmodule

// File: rtl/fp32_rne_add.sv
module fp32_rne_add
  import bf16_mac_pkg::*;
(
  input  logic [FP_W-1:0] x_i,
  input  logic [FP_W-1:0] y_i,
  output logic [FP_W-1:0] sum_o
);
  function automatic logic [LZ_W-1:0] lzc(input logic [ALN_W-1:0] v);
    logic [LZ_W-1:0] n;
    logic            hit;
    n   = '0;
    hit = 1'b0;
    for (int i = ALN_W - 1; i >= 0; i--) begin
      if (!hit && v[i]) begin
        n   = LZ_W'(ALN_W - 1 - i);
        hit = 1'b1;
      end
    end
    return n;
  endfunction

  logic              x_zero, y_zero, x_inf, y_inf, x_nan, y_nan;
  logic              x_big, sb, eff_sub;
  logic [FP_W-1:0]   big, sml;
  logic [7:0]        diff;
  logic [ALN_W-1:0]  mb, ms, ms_al, mask, norm;
  logic [ALN_W:0]    sum;
  logic [LZ_W-1:0]   lz;
  logic signed [9:0] exp_n, exp_r;
  logic              rnd_up;
  logic [SIG_W:0]    mant_r;
  logic [FP_FW-1:0]  frac_r;
  logic [FP_W-1:0]   gen_res;

  assign x_zero = (x_i[30:23] == '0);
  assign y_zero = (y_i[30:23] == '0);
  assign x_inf  = (x_i[30:23] == '1) && (x_i[22:0] == '0);
  assign y_inf  = (y_i[30:23] == '1) && (y_i[22:0] == '0);
  assign x_nan  = (x_i[30:23] == '1) && (x_i[22:0] != '0);
  assign y_nan  = (y_i[30:23] == '1) && (y_i[22:0] != '0);

  assign x_big   = (x_i[30:0] >= y_i[30:0]);
  assign big     = x_big ? x_i : y_i;
  assign sml     = x_big ? y_i : x_i;
  assign sb      = big[31];
  assign eff_sub = big[31] ^ sml[31];
  assign diff    = big[30:23] - sml[30:23];
  assign mb      = {1'b1, big[22:0], {GRS_W{1'b0}}};
  assign ms      = {1'b1, sml[22:0], {GRS_W{1'b0}}};
  assign mask    = ~({ALN_W{1'b1}} << diff);

  // align with sticky collapse into bit 0
  always_comb begin
    if (diff >= 8'(ALN_W))
      ms_al = {{(ALN_W-1){1'b0}}, 1'b1};
    else
      ms_al = (ms >> diff) | {{(ALN_W-1){1'b0}}, |(ms & mask)};
  end

  assign sum = eff_sub ? ({1'b0, mb} - {1'b0, ms_al}) : ({1'b0, mb} + {1'b0, ms_al});
  assign lz  = lzc(sum[ALN_W-1:0]);

  always_comb begin
    if (sum[ALN_W]) begin
      norm  = {sum[ALN_W:2], sum[1] | sum[0]};
      exp_n = $signed({2'b00, big[30:23]}) + 10'sd1;
    end else begin
      norm  = sum[ALN_W-1:0] << lz;
      exp_n = $signed({2'b00, big[30:23]}) - $signed({{(10-LZ_W){1'b0}}, lz});
    end
  end

  assign rnd_up = norm[2] && (norm[1] || norm[0] || norm[3]);
  assign mant_r = {1'b0, norm[ALN_W-1:GRS_W]} + {{SIG_W{1'b0}}, rnd_up};

  always_comb begin
    if (mant_r[SIG_W]) begin
      frac_r = mant_r[SIG_W-1:1];
      exp_r  = exp_n + 10'sd1;
    end else begin
      frac_r = mant_r[FP_FW-1:0];
      exp_r  = exp_n;
    end
  end

  always_comb begin
    if (sum == '0)
      gen_res = '0;
    else if (exp_r >= 10'sd255)
      gen_res = {sb, {FP_EW{1'b1}}, {FP_FW{1'b0}}};
    else if (exp_r <= 10'sd0)
      gen_res = {sb, {(FP_W-1){1'b0}}};
    else
      gen_res = {sb, exp_r[7:0], frac_r};
  end

  always_comb begin
    if (x_nan || y_nan || (x_inf && y_inf && (x_i[31] != y_i[31])))
      sum_o = QNAN;
    else if (x_inf)
      sum_o = x_i;
    else if (y_inf)
      sum_o = y_i;
    else if (x_zero && y_zero)
      sum_o = {x_i[31] & y_i[31], {(FP_W-1){1'b0}}};
    else if (x_zero)
      sum_o = y_i;
    else if (y_zero)
      sum_o = x_i;
    else
      sum_o = gen_res;
  end
endmodule

// File: rtl/bf16_mac_acc.sv
module bf16_mac_acc
  import bf16_mac_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            clear_i,
  input  logic [15:0]     a_i,
  input  logic [15:0]     b_i,
  output logic [FP_W-1:0] acc_o
);
  logic            s1_vld, s1_clr;
  logic [FP_W-1:0] prod_w, s1_prod, base_w, add_w, acc_q;

  bf16_mul_widen u_mul (
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_clr  <= 1'b0;
      s1_prod <= '0;
    end else begin
      s1_vld  <= valid_i;
      s1_clr  <= clear_i;
      s1_prod <= prod_w;
    end
  end

  // clear folds into the add so the first term lands in the same cycle
  assign base_w = s1_clr ? '0 : acc_q;

  fp32_rne_add u_add (
    .x_i   (base_w),
    .y_i   (s1_prod),
    .sum_o (add_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      acc_q <= '0;
    else if (s1_vld)
      acc_q <= add_w;
    else if (s1_clr)
      acc_q <= '0;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/bf16_mac_acc_chk.sv
module bf16_mac_acc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        clear_i,
  input logic [15:0] a_i,
  input logic [15:0] b_i,
  input logic [31:0] acc_o
);
  logic [1:0] cyc_q;
  logic       ok_w, a_nan_w, b_nan_w, a_inf_w, b_fin_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  assign ok_w    = (cyc_q >= 2'd2);
  assign a_nan_w = (a_i[14:7] == 8'hff) && (a_i[6:0] != '0);
  assign b_nan_w = (b_i[14:7] == 8'hff) && (b_i[6:0] != '0);
  assign a_inf_w = (a_i[14:7] == 8'hff) && (a_i[6:0] == '0);
  assign b_fin_w = (b_i[14:7] != 8'hff) && (b_i[14:7] != 8'h00);

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_w && !$past(valid_i, 2) && !$past(clear_i, 2)) |-> (acc_o == $past(acc_o)));

  // R5
  lone_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_w && $past(clear_i, 2) && !$past(valid_i, 2)) |-> (acc_o == 32'h0));

  // R8
  nan_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_w && $past(valid_i && (a_nan_w || b_nan_w), 2)) |-> (acc_o == 32'h7FC0_0000));

  // R9
  inf_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_w && $past(valid_i && clear_i && a_inf_w && b_fin_w, 2))
      |-> (acc_o == {$past(a_i[15] ^ b_i[15], 2), 8'hff, 23'h0}));
endmodule

bind bf16_mac_acc bf16_mac_acc_chk u_chk (.*);

// File: tb/bf16_mac_acc_tb.sv
`timescale 1ns/1ps
module bf16_mac_acc_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        clear_i = 1'b0;
  logic [15:0] a_i = '0;
  logic [15:0] b_i = '0;
  logic [31:0] acc_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  logic [31:0] ref_acc = '0;

  int          due_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [31:0] QN = 32'h7FC0_0000;

  bf16_mac_acc u_dut (.*);

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic real f2r(input logic [31:0] x);
    int e;
    if (x[30:23] == 0) return $bitstoreal({x[31], 63'b0});
    e = int'(x[30:23]) - 127 + 1023;
    return $bitstoreal({x[31], e[10:0], x[22:0], 29'b0});
  endfunction

  function automatic logic [31:0] r2f(input real r);
    logic [63:0] d;
    logic [52:0] m53;
    logic [24:0] k;
    logic [28:0] rem;
    int fe;
    d = $realtobits(r);
    if (d[62:52] == 0) return {d[63], 31'b0};
    m53 = {1'b1, d[51:0]};
    k   = {1'b0, m53[52:29]};
    rem = m53[28:0];
    if (rem > 29'h1000_0000 || (rem == 29'h1000_0000 && k[0])) k = k + 1;
    fe = int'(d[62:52]) - 1023 + 127;
    if (k[24]) begin fe++; k = k >> 1; end
    if (fe >= 255) return {d[63], 8'hff, 23'b0};
    if (fe <= 0) return {d[63], 31'b0};
    return {d[63], fe[7:0], k[22:0]};
  endfunction

  function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
    logic an, bn, ai, bi, az, bz, s;
    an = a[14:7] == 8'hff && a[6:0] != 0;  bn = b[14:7] == 8'hff && b[6:0] != 0;
    ai = a[14:7] == 8'hff && a[6:0] == 0;  bi = b[14:7] == 8'hff && b[6:0] == 0;
    az = a[14:7] == 0;                     bz = b[14:7] == 0;
    s  = a[15] ^ b[15];
    if (an || bn || (ai && bz) || (bi && az)) return QN;
    if (ai || bi) return {s, 8'hff, 23'b0};
    if (az || bz) return {s, 31'b0};
    return r2f(f2r({a, 16'b0}) * f2r({b, 16'b0}));
  endfunction

  function automatic logic [31:0] ref_add(input logic [31:0] x, input logic [31:0] y);
    logic xn, yn, xi, yi, xz, yz;
    real r;
    xn = x[30:23] == 8'hff && x[22:0] != 0;  yn = y[30:23] == 8'hff && y[22:0] != 0;
    xi = x[30:23] == 8'hff && x[22:0] == 0;  yi = y[30:23] == 8'hff && y[22:0] == 0;
    xz = x[30:23] == 0;                      yz = y[30:23] == 0;
    if (xn || yn || (xi && yi && x[31] != y[31])) return QN;
    if (xi) return x;
    if (yi) return y;
    if (xz && yz) return {x[31] & y[31], 31'b0};
    if (xz) return y;
    if (yz) return x;
    r = f2r(x) + f2r(y);
    if (r == 0.0) return 32'h0;
    return r2f(r);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: acc_o=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // driver: called at a negedge, leaves at the next negedge
  task automatic op(input logic [15:0] a, input logic [15:0] b,
                    input logic v, input logic c, input string tag);
    a_i = a; b_i = b; valid_i = v; clear_i = c;
    if (v) ref_acc = ref_add(c ? 32'h0 : ref_acc, ref_mul(a, b));
    else if (c) ref_acc = 32'h0;
    due_q.push_back(cyc + 2);
    exp_q.push_back(ref_acc);
    tag_q.push_back(tag);
    @(negedge clk_i);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      while (due_q.size() > 0 && due_q[0] == cyc) begin
        void'(due_q.pop_front());
        check(acc_o, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    #400000;
    n_bad++;
    $display("FAIL R3 watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check(acc_o, 32'h0, "R1");

    // dot product, back to back
    op(16'h3F80, 16'h40E0, 1, 1, "R4");
    op(16'h4000, 16'h4130, 1, 0, "R3");
    op(16'h4040, 16'h4170, 1, 0, "R2");
    op(16'h7FC1, 16'h7F80, 0, 0, "R6");
    op(16'h1234, 16'hFFFF, 0, 0, "R6");
    check(acc_o, 32'h4294_0000, "R2");
    op(16'h0000, 16'h0000, 0, 0, "R6");

    op(16'h0000, 16'h0000, 0, 1, "R5");

    // ties to even
    op(16'h3F80, 16'h3F80, 1, 1, "R4");
    op(16'h3380, 16'h3F80, 1, 0, "R7");
    op(16'h3400, 16'h3F80, 1, 0, "R7");
    op(16'h3380, 16'h3F80, 1, 0, "R7");
    op(16'h0000, 16'h0000, 0, 0, "R6");
    op(16'h0000, 16'h0000, 0, 0, "R6");
    check(acc_o, 32'h3F80_0002, "R7");

    // NaN cases
    op(16'h7FC1, 16'h3F80, 1, 0, "R8");
    op(16'h4000, 16'h4000, 1, 1, "R4");
    op(16'h7F80, 16'h0000, 1, 0, "R8");
    op(16'h7F80, 16'h3F80, 1, 1, "R9");
    op(16'hFF80, 16'h3F80, 1, 0, "R8");

    // infinity sign and absorption
    op(16'hFF80, 16'h4000, 1, 1, "R9");
    op(16'h4040, 16'h4170, 1, 0, "R9");
    op(16'h7F80, 16'hBF80, 1, 1, "R9");

    // flush and overflow
    op(16'h3F80, 16'h3F80, 1, 1, "R4");
    op(16'h0040, 16'h7F00, 1, 0, "R10");
    op(16'h7F00, 16'h4000, 1, 1, "R10");
    op(16'h0080, 16'h3F80, 1, 1, "R10");
    op(16'h8080, 16'h3F40, 1, 0, "R10");
    op(16'h80C0, 16'h3F80, 1, 0, "R10");

    // cancellation
    op(16'h3F80, 16'h4000, 1, 1, "R4");
    op(16'hBF80, 16'h4000, 1, 0, "R11");
    op(16'hC0A0, 16'h3FC0, 1, 1, "R4");
    op(16'h40A0, 16'h3FC0, 1, 0, "R11");

    // random stream
    for (int i = 0; i < 300; i++) begin
      logic [15:0] ra, rb;
      ra = {1'($urandom), 8'(120 + $urandom_range(0, 14)), 7'($urandom)};
      rb = {1'($urandom), 8'(120 + $urandom_range(0, 14)), 7'($urandom)};
      op(ra, rb, ($urandom_range(0, 7) != 0), (i % 16 == 0), "R2");
    end

    repeat (4) @(negedge clk_i);
    n_cmp++;
    if (due_q.size() != 0) begin
      n_bad++;
      $display("FAIL R3: pending=%0d expected 0", due_q.size());
    end
    finish_run();
  end
endmodule